// File: doc/BRIEF.md
# Two-Bank DRAM Command Front End

This block sits at the command input of a two-bank, 32-bit graphics DRAM model or controller. At each rising clock edge it takes the chip-select, row strobe, column strobe, write-enable and special-function inputs, the multiplexed address bus and the per-byte mask lanes. It turns them into activate, read, write, precharge and auto-refresh operations. It keeps an open or closed flag and the latched row address for each bank. It runs a burst timer that closes a bank at the end of a burst when auto precharge was asked for. It also produces the byte masks that apply to read data and to write data.

The top address bit picks the bank. The bit just below it selects auto precharge on column commands and "all banks" on precharge. The low bits carry the row on an activate and the column on a read or write. A clock-enable input gates the edges: an edge counts only if clock enable was high at the previous edge. A suspended edge changes no state and produces no pulse. Accepted column commands, accepted refreshes and rejected commands each appear as a one-cycle registered pulse.

Top module: `dram_cmd_front`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh. With cs_n high, or with the special-function input high, the edge carries no command: bank state, rows, col_valid, ref_pulse and cmd_err are unaffected.
- R2: An activate to a closed bank opens it and stores addr[8:0] as its row. addr[9]=0 selects bank A (bank_open[0], open_rows[8:0]) and addr[9]=1 selects bank B (bank_open[1], open_rows[17:9]).
- R3: An activate to a bank that is already open pulses cmd_err for one cycle and leaves that bank's row unchanged.
- R4: A read or write to an open bank pulses col_valid in the cycle after the edge, with col_addr=addr[7:0], col_bank=addr[9] and col_is_wr=1 for a write. burst_busy is high for BURST_LEN (default 4) cycles starting with that same cycle.
- R5: A read or write to a closed bank pulses cmd_err and produces no col_valid.
- R6: A read or write with addr[8]=1 closes its bank at the edge BURST_LEN edges after the command. With addr[8]=0 the bank stays open after the burst.
- R7: A precharge with addr[8]=1 closes both banks. With addr[8]=0 it closes only the bank chosen by addr[9].
- R8: An auto refresh is accepted only when both banks are closed. An accepted refresh pulses ref_pulse and advances ref_row by one, wrapping from REF_ROWS-1 (default 1023) to 0. Otherwise it pulses cmd_err and ref_row holds.
- R9: Byte masks act whether or not cs_n is high. wr_dqm shows the mask sampled at the latest effective edge. rd_dqm shows the mask sampled two effective edges before the latest one.
- R10: An edge is effective only if cke was high at the previous edge. At a suspended edge, bank state, rows, masks and ref_row hold, and col_valid, ref_pulse and cmd_err go low.
- R11: A read or write issued while an auto-precharge burst is still running pulses cmd_err and is ignored. A column command during a burst without auto precharge restarts the burst.
- R12: After reset both banks are closed, rows and ref_row are zero, both mask outputs are zero and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; gates the following edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| sfn | input | 1 | Special-function select; high suppresses normal decode |
| addr | input | 10 | Bank bit [9], auto-precharge/all bit [8], row [8:0], column [7:0] |
| bmask | input | 4 | Byte mask lanes, high masks the lane |
| bank_open | output | 2 | Open flag per bank (bit 0 bank A) |
| open_rows | output | 18 | Latched rows, bank A in [8:0], bank B in [17:9] |
| col_valid | output | 1 | Pulse: column command accepted |
| col_is_wr | output | 1 | Accepted column command was a write |
| col_bank | output | 1 | Bank of the accepted column command |
| col_addr | output | 8 | Column of the accepted column command |
| burst_busy | output | 1 | Burst in progress |
| ref_pulse | output | 1 | Pulse: refresh accepted |
| ref_row | output | 10 | Refresh row counter |
| cmd_err | output | 1 | Pulse: illegal command rejected |
| rd_dqm | output | 4 | Mask applied to read data |
| wr_dqm | output | 4 | Mask applied to write data |

## Verification
The assertions assume that reset is held for at least one edge at start-up. They also assume that the inputs are settled at every rising edge, so that each effective edge carries exactly one decoded command. The bench changes every input 1 ns after a rising edge and samples the outputs at that same point. This keeps the stimulus clear of the edge, so no result depends on process order. Illegal sequences, such as an activate to an open bank, a column command to a closed bank, or a column command during an auto-precharge burst, are issued on purpose, but only one per edge and only from a known bank state, so each expected pulse is unambiguous.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF
  } cmd_e;
endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
  import dram_cmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic sfn,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n && !sfn) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/dram_bank_slot.sv
module dram_bank_slot #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             act,
  input  logic             close,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (en) begin
      if (act) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end else if (close) begin
        open_q <= 1'b0;
      end
    end
  end

  // R3: the front end only activates a bank that is closed
  a_r3_act_only_closed: assert property (@(posedge clk) disable iff (rst)
    (en && act) |-> !open_q);

  // R2: an open bank keeps its row until something closes it
  a_r2_row_held: assert property (@(posedge clk) disable iff (rst)
    (open_q && !(en && close)) |=> (open_q && $stable(row_q)));
endmodule

// File: rtl/dram_burst_timer.sv
module dram_burst_timer #(
  parameter int BURST_LEN = 4,
  parameter int BANKS     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     start,
  input  logic                     ap_in,
  input  logic [$clog2(BANKS)-1:0] bank_in,
  output logic                     busy,
  output logic                     ap_busy,
  output logic [BANKS-1:0]         close_req
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam int BW    = $clog2(BANKS);

  logic [CNT_W-1:0] rem;
  logic             ap_q;
  logic [BW-1:0]    bank_q;
  logic             last_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (en) begin
      if (start) begin
        rem    <= CNT_W'(BURST_LEN);
        ap_q   <= ap_in;
        bank_q <= bank_in;
      end else if (rem != '0) begin
        rem <= rem - 1'b1;
        if (rem == CNT_W'(1)) ap_q <= 1'b0;
      end
    end
  end

  assign busy      = (rem != '0);
  assign ap_busy   = ap_q && busy;
  assign last_beat = en && !start && (rem == CNT_W'(1));

  for (genvar b = 0; b < BANKS; b++) begin : g_close
    assign close_req[b] = last_beat && ap_q && (bank_q == BW'(b));
  end

  // R11: no new burst may start on top of an auto-precharge burst
  a_r11_no_start_in_ap: assert property (@(posedge clk) disable iff (rst)
    (en && ap_busy) |-> !start);

  // R4: a started burst is visible as busy on the next cycle
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    (en && start) |=> busy);

  // R6: the last beat ends the burst
  a_r6_burst_ends: assert property (@(posedge clk) disable iff (rst)
    last_beat |=> !busy);
endmodule

// File: rtl/dram_mask_pipe.sv
module dram_mask_pipe #(
  parameter int LANES  = 4,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] rd_mask,
  output logic [LANES-1:0] wr_mask
);
  logic [RD_LAT:0][LANES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst)     stg[0] <= '0;
    else if (en) stg[0] <= mask_in;
  end

  for (genvar i = 1; i <= RD_LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)     stg[i] <= '0;
      else if (en) stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     wr_mask <= '0;
    else if (en) wr_mask <= mask_in;
  end

  assign rd_mask = stg[RD_LAT];
endmodule

// File: rtl/dram_cmd_front.sv
module dram_cmd_front
  import dram_cmd_pkg::*;
#(
  parameter int ROW_W       = 9,
  parameter int COL_W       = 8,
  parameter int LANES       = 4,
  parameter int BURST_LEN   = 4,
  parameter int REF_ROWS    = 1024,
  parameter int RD_MASK_LAT = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic                          sfn,
  input  logic [ROW_W:0]                addr,
  input  logic [LANES-1:0]              bmask,
  output logic [1:0]                    bank_open,
  output logic [2*ROW_W-1:0]            open_rows,
  output logic                          col_valid,
  output logic                          col_is_wr,
  output logic                          col_bank,
  output logic [COL_W-1:0]              col_addr,
  output logic                          burst_busy,
  output logic                          ref_pulse,
  output logic [$clog2(REF_ROWS)-1:0]   ref_row,
  output logic                          cmd_err,
  output logic [LANES-1:0]              rd_dqm,
  output logic [LANES-1:0]              wr_dqm
);
  localparam int BANKS    = 2;
  localparam int BANK_BIT = ROW_W;
  localparam int AP_BIT   = ROW_W - 1;
  localparam int REF_W    = $clog2(REF_ROWS);

  cmd_e             cmd;
  logic             cke_q;
  logic             eff;
  logic             sel_bank;
  logic             sel_open;
  logic             col_cmd;
  logic             col_ok;
  logic             act_ok;
  logic             ref_ok;
  logic             err_now;
  logic             ap_busy;
  logic [BANKS-1:0] close_req;
  logic [BANKS-1:0] pre_hit;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b0;
    else     cke_q <= cke;
  end
  assign eff = cke_q;

  dram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .sfn  (sfn),
    .cmd  (cmd)
  );

  assign sel_bank = addr[BANK_BIT];
  assign sel_open = bank_open[sel_bank];
  assign col_cmd  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign col_ok   = col_cmd && sel_open && !ap_busy;
  assign act_ok   = (cmd == CMD_ACT) && !sel_open;
  assign ref_ok   = (cmd == CMD_REF) && (bank_open == '0);
  assign err_now  = (col_cmd && !col_ok)
                  || ((cmd == CMD_ACT) && sel_open)
                  || ((cmd == CMD_REF) && !ref_ok);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign pre_hit[b] = (cmd == CMD_PRE) && (addr[AP_BIT] || (sel_bank == 1'(b)));

    dram_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .en    (eff),
      .act   (act_ok && (sel_bank == 1'(b))),
      .close (pre_hit[b] || close_req[b]),
      .row_in(addr[ROW_W-1:0]),
      .open_q(bank_open[b]),
      .row_q (open_rows[b*ROW_W +: ROW_W])
    );
  end

  dram_burst_timer #(.BURST_LEN(BURST_LEN), .BANKS(BANKS)) u_burst (
    .clk      (clk),
    .rst      (rst),
    .en       (eff),
    .start    (col_ok),
    .ap_in    (addr[AP_BIT]),
    .bank_in  (sel_bank),
    .busy     (burst_busy),
    .ap_busy  (ap_busy),
    .close_req(close_req)
  );

  dram_mask_pipe #(.LANES(LANES), .RD_LAT(RD_MASK_LAT)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .en     (eff),
    .mask_in(bmask),
    .rd_mask(rd_dqm),
    .wr_mask(wr_dqm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_is_wr <= 1'b0;
      col_bank  <= 1'b0;
      col_addr  <= '0;
      ref_pulse <= 1'b0;
      ref_row   <= '0;
      cmd_err   <= 1'b0;
    end else if (eff) begin
      col_valid <= col_ok;
      ref_pulse <= ref_ok;
      cmd_err   <= err_now;
      if (col_ok) begin
        col_is_wr <= (cmd == CMD_WR);
        col_bank  <= sel_bank;
        col_addr  <= addr[COL_W-1:0];
      end
      if (ref_ok) begin
        ref_row <= (ref_row == REF_W'(REF_ROWS - 1)) ? '0 : ref_row + 1'b1;
      end
    end else begin
      col_valid <= 1'b0;
      ref_pulse <= 1'b0;
      cmd_err   <= 1'b0;
    end
  end

  // R1: a deselected edge neither accepts nor rejects anything
  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    (eff && cs_n) |=> (!col_valid && !cmd_err && !ref_pulse && $stable(open_rows)));

  // R10: a suspended edge freezes bank state and drops pulses
  a_r10_suspend_quiet: assert property (@(posedge clk) disable iff (rst)
    !cke_q |=> (!col_valid && !cmd_err && !ref_pulse && $stable(bank_open) && $stable(ref_row)));

  // R8: a refresh is only accepted with every bank closed
  a_r8_ref_closed: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |-> (bank_open == '0));

  // R5: an accepted column command targets an open bank
  a_r5_col_open: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> bank_open[col_bank]);

  // R3: a reported error excludes any acceptance pulse
  a_r3_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (!col_valid && !ref_pulse));
endmodule

// File: tb/sim_dram_cmd_front.sv
module sim_dram_cmd_front;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_DPR = 4'b1010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic        sfn = 1'b0;
  logic [9:0]  addr = '0;
  logic [3:0]  bmask = '0;
  logic [1:0]  bank_open;
  logic [17:0] open_rows;
  logic        col_valid, col_is_wr, col_bank, burst_busy, ref_pulse, cmd_err;
  logic [7:0]  col_addr;
  logic [9:0]  ref_row;
  logic [3:0]  rd_dqm, wr_dqm;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dram_cmd_front u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .sfn(sfn), .addr(addr), .bmask(bmask), .bank_open(bank_open),
    .open_rows(open_rows), .col_valid(col_valid), .col_is_wr(col_is_wr),
    .col_bank(col_bank), .col_addr(col_addr), .burst_busy(burst_busy),
    .ref_pulse(ref_pulse), .ref_row(ref_row), .cmd_err(cmd_err),
    .rd_dqm(rd_dqm), .wr_dqm(wr_dqm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [3:0] c, input logic [9:0] a, input logic [3:0] m);
    {cs_n, ras_n, cas_n, we_n} = c;
    addr  = a;
    bmask = m;
    tick();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) issue(C_NOP, 10'h0, 4'h0);
    check("R12 bank_open", 32'(bank_open), 32'h0);
    check("R12 rows", 32'(open_rows), 32'h0);
    check("R12 pulses", {29'h0, col_valid, ref_pulse, cmd_err}, 32'h0);
    check("R12 ref_row", 32'(ref_row), 32'h0);
    check("R12 masks", {24'h0, rd_dqm, wr_dqm}, 32'h0);
    rst = 1'b0;
    issue(C_NOP, 10'h0, 4'h0);
  endtask

  task automatic t_activate();
    issue(C_ACT, {1'b0, 9'h1A5}, 4'h0);
    check("R2 open A", 32'(bank_open), 32'h1);
    check("R2 row A", 32'(open_rows[8:0]), 32'h1A5);
    issue(C_ACT, {1'b1, 9'h0F3}, 4'h0);
    check("R2 open B", 32'(bank_open), 32'h3);
    check("R2 row B", 32'(open_rows[17:9]), 32'h0F3);
    check("R2 no err", 32'(cmd_err), 32'h0);
  endtask

  task automatic t_act_err();
    issue(C_ACT, {1'b0, 9'h055}, 4'h0);
    check("R3 err", 32'(cmd_err), 32'h1);
    check("R3 row kept", 32'(open_rows[8:0]), 32'h1A5);
    issue(C_NOP, 10'h0, 4'h0);
    check("R3 err one cycle", 32'(cmd_err), 32'h0);
  endtask

  task automatic t_deselect();
    issue(C_DPR, 10'h100, 4'h0);
    check("R1 cs high ignored", 32'(bank_open), 32'h3);
    check("R1 cs high no err", 32'(cmd_err), 32'h0);
    sfn = 1'b1;
    issue(C_PRE, 10'h100, 4'h0);
    sfn = 1'b0;
    check("R1 sfn high ignored", 32'(bank_open), 32'h3);
  endtask

  task automatic t_read();
    issue(C_RD, {1'b0, 1'b0, 8'h3C}, 4'h0);
    check("R4 col_valid", 32'(col_valid), 32'h1);
    check("R4 fields", {22'h0, col_is_wr, col_bank, col_addr}, {22'h0, 2'b00, 8'h3C});
    check("R4 busy", 32'(burst_busy), 32'h1);
    for (int i = 1; i < 4; i++) begin
      issue(C_NOP, 10'h0, 4'h0);
      check("R4 busy hold", {30'h0, col_valid, burst_busy}, 32'h1);
    end
    issue(C_NOP, 10'h0, 4'h0);
    check("R4 busy end", 32'(burst_busy), 32'h0);
    check("R6 no ap stays open", 32'(bank_open), 32'h3);
  endtask

  task automatic t_write_ap();
    issue(C_WR, {1'b1, 1'b1, 8'h81}, 4'h0);
    check("R4 write fields", {21'h0, col_valid, col_is_wr, col_bank, col_addr}, {21'h0, 3'b111, 8'h81});
    issue(C_RD, {1'b0, 1'b0, 8'h10}, 4'h0);
    check("R11 err during ap", {30'h0, cmd_err, col_valid}, 32'h2);
    issue(C_NOP, 10'h0, 4'h0);
    issue(C_NOP, 10'h0, 4'h0);
    check("R6 open before end", {29'h0, burst_busy, bank_open}, 32'h7);
    issue(C_NOP, 10'h0, 4'h0);
    check("R6 closed at end", {29'h0, burst_busy, bank_open}, 32'h1);
  endtask

  task automatic t_read_closed();
    issue(C_RD, {1'b1, 1'b0, 8'h22}, 4'h0);
    check("R5 err closed", {30'h0, cmd_err, col_valid}, 32'h2);
  endtask

  task automatic t_ref_err();
    issue(C_REF, 10'h0, 4'h0);
    check("R8 ref rejected", {30'h0, cmd_err, ref_pulse}, 32'h2);
    check("R8 ref_row held", 32'(ref_row), 32'h0);
  endtask

  task automatic t_precharge();
    issue(C_PRE, {1'b0, 1'b0, 8'h00}, 4'h0);
    check("R7 close A", 32'(bank_open), 32'h0);
    issue(C_ACT, {1'b0, 9'h011}, 4'h0);
    issue(C_ACT, {1'b1, 9'h122}, 4'h0);
    issue(C_PRE, {1'b1, 1'b0, 8'h00}, 4'h0);
    check("R7 close B only", 32'(bank_open), 32'h1);
    issue(C_ACT, {1'b1, 9'h122}, 4'h0);
    issue(C_PRE, {1'b0, 1'b1, 8'h00}, 4'h0);
    check("R7 close all", 32'(bank_open), 32'h0);
  endtask

  task automatic t_refresh();
    for (int i = 1; i <= 1024; i++) begin
      issue(C_REF, 10'h0, 4'h0);
      if (i == 1 || i == 2 || i == 1023 || i == 1024) begin
        check("R8 ref accepted", 32'(ref_pulse), 32'h1);
        check("R8 ref_row", 32'(ref_row), 32'(i % 1024));
      end
    end
  endtask

  task automatic t_mask();
    issue(C_NOP, 10'h0, 4'h1);
    check("R9 wr mask", 32'(wr_dqm), 32'h1);
    issue(C_DES, 10'h0, 4'h2);
    check("R9 wr mask deselected", 32'(wr_dqm), 32'h2);
    issue(C_NOP, 10'h0, 4'h4);
    check("R9 rd mask lat", {24'h0, rd_dqm, wr_dqm}, 32'h14);
    issue(C_DES, 10'h0, 4'h8);
    check("R9 rd mask next", {24'h0, rd_dqm, wr_dqm}, 32'h28);
    issue(C_NOP, 10'h0, 4'h0);
    issue(C_NOP, 10'h0, 4'h0);
    check("R9 rd mask tail", 32'(rd_dqm), 32'h8);
  endtask

  task automatic t_cke();
    cke = 1'b0;
    issue(C_NOP, 10'h0, 4'h0);
    issue(C_ACT, {1'b0, 9'h077}, 4'hF);
    check("R10 suspended act", 32'(bank_open), 32'h0);
    check("R10 suspended mask", 32'(wr_dqm), 32'h0);
    cke = 1'b1;
    issue(C_ACT, {1'b0, 9'h077}, 4'h0);
    check("R10 cke one cycle early", 32'(bank_open), 32'h0);
    issue(C_ACT, {1'b0, 9'h077}, 4'h0);
    check("R10 resumed act", 32'(bank_open), 32'h1);
    check("R10 resumed row", 32'(open_rows[8:0]), 32'h077);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_activate();
    t_act_err();
    t_deselect();
    t_read();
    t_write_ap();
    t_read_closed();
    t_ref_err();
    t_precharge();
    t_refresh();
    t_mask();
    t_cke();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule